// File: doc/BRIEF.md
# Clock Root Configuration Update Controller

This block is the register front end of one clock root generator. Software programs a shadow set of configuration values through a simple 32-bit register port. The set covers source choice, pre-divider, counter mode, hardware-control flag and the three counter values for the fractional divider. Nothing in the shadow set reaches the clock hardware until software requests an update. The block then copies the entire shadow set into the active copy on one clock edge, so the downstream mux and dividers never see a half-written configuration.

The update request is a self-clearing flag in the command word. Software sets it and then polls it until it reads back as zero, which means the active outputs now carry the new values. The same command word reports, in a read-only flag, whether the root clock is currently running. That flag is taken from an enable input. The register port is control traffic with a fixed single-cycle write and a combinational read, so it carries no valid/ready handshake and never applies back-pressure.

Top module: `clkroot_ctrl`

## Requirements
- R1: After reset, all shadow registers and all active outputs are zero and the update flag (command bit 0) reads 0.
- R2: The configuration word at byte offset GRP_OFS+4 stores the pre-divider in bits [DIV_SHIFT+HID_W-1:DIV_SHIFT] (defaults [4:0]), the source select in bits [10:8], the mode in bits [13:12] and the hardware-control flag in bit 20. All other bits read as 0.
- R3: The counter words M (GRP_OFS+8), N (GRP_OFS+12) and D (GRP_OFS+16) keep all 32 written bits on read-back. The active counter outputs carry only their low MND_W bits.
- R4: Writing the command word (offset 0) with bit 0 set makes bit 0 read 1 from the next cycle onward until the update completes. Writing bit 0 as 0 never clears a pending update or starts one.
- R5: The active copy changes on the second clock edge after the edge that set the update flag. The update flag reads 0 from that same edge. Exactly one load happens per request.
- R6: Writes to the configuration or counter words never change the active outputs except through an update load.
- R7: Writes made while an update is pending are accepted into the shadow set, and the load takes whatever the shadow set holds just before the load edge.
- R8: Command bit 31 reads 1 when the root enable input is 0, and reads 0 when it is 1. All other command bits except bit 0 read 0.
- R9: Accesses to addresses outside the five words described above are ignored on write and read as 0.
- R10: A new update request written on the load edge of the previous one starts a fresh request, and that request loads two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| root_en | input | 1 | Root clock running indication |
| act_src_sel | output | SRC_W | Active source select |
| act_pre_div | output | HID_W | Active pre-divider |
| act_mode | output | 2 | Active counter mode |
| act_hw_ctrl | output | 1 | Active hardware-control flag |
| act_m | output | MND_W | Active M counter value |
| act_n | output | MND_W | Active N counter value |
| act_d | output | MND_W | Active D counter value |

## Verification
Register reads are combinational. Each read is sampled 1 ns after the falling edge that follows a write, so a written value is checked in the same cycle as the write edge. The active outputs are due exactly two edges after the write edge that sets the update flag. The driver records the cycle number of that write edge and queues the expected active set together with its due cycle. A monitor compares each change it sees on the active outputs against the head of the queue, checking both the value and the cycle number. Any change with no queued entry, and any entry still queued at the end, counts as an error. The update flag is polled at the falling edges of the write cycle, the next cycle and the load cycle, so both its one-cycle hold and its two-cycle clear are pinned down.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  // Word offsets inside the configuration group, relative to GRP_OFS
  localparam int OFS_CFG = 4;
  localparam int OFS_M   = 8;
  localparam int OFS_N   = 12;
  localparam int OFS_D   = 16;
  // Command word bit positions
  localparam int CMD_UPD_BIT  = 0;
  localparam int CMD_OFF_BIT  = 31;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_CFG,
    SEL_M,
    SEL_N,
    SEL_D
  } reg_sel_e;
endpackage

// File: rtl/clkroot_upd_seq.sv
module clkroot_upd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic pending,
  output logic load
);
  logic pend_q, stage_q;

  assign pending = pend_q;
  assign load    = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= 1'b0;
    end else begin
      pend_q  <= set_req | (pend_q & ~stage_q);
      stage_q <= pend_q & ~stage_q;
    end
  end

  // R5: a load only ever happens for a pending request
  p_load_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> pending);
  // R5: one load per request
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R5: the flag clears on the load edge unless re-armed
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !set_req) |=> !pending);
  // R4: a pending request is held until its load
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !load) |=> pending);
  // R4, R10: a set always arms the flag
  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> pending);
endmodule

// File: rtl/clkroot_shadow.sv
module clkroot_shadow
  import clkroot_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int GRP_OFS    = 32,
  parameter int HID_W      = 5,
  parameter int DIV_SHIFT  = 0,
  parameter int SRC_W      = 3,
  parameter int SRC_SHIFT  = 8,
  parameter int MODE_SHIFT = 12,
  parameter int HW_BIT     = 20,
  parameter int MND_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              root_en,
  input  logic              pending,
  output logic              set_req,
  output logic [SRC_W-1:0]  sh_src,
  output logic [HID_W-1:0]  sh_div,
  output logic [1:0]        sh_mode,
  output logic              sh_hw,
  output logic [MND_W-1:0]  sh_m,
  output logic [MND_W-1:0]  sh_n,
  output logic [MND_W-1:0]  sh_d
);
  localparam int NCNT = 3;

  reg_sel_e    sel;
  logic [31:0] cnt_q [NCNT];
  logic [NCNT-1:0] cnt_hit;

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr == ADDR_W'(0))                 sel = SEL_CMD;
    else if (reg_addr == ADDR_W'(GRP_OFS + OFS_CFG)) sel = SEL_CFG;
    else if (reg_addr == ADDR_W'(GRP_OFS + OFS_M))   sel = SEL_M;
    else if (reg_addr == ADDR_W'(GRP_OFS + OFS_N))   sel = SEL_N;
    else if (reg_addr == ADDR_W'(GRP_OFS + OFS_D))   sel = SEL_D;
  end

  assign set_req = reg_wr && (sel == SEL_CMD) && reg_wdata[CMD_UPD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_src  <= '0;
      sh_div  <= '0;
      sh_mode <= '0;
      sh_hw   <= 1'b0;
    end else if (reg_wr && sel == SEL_CFG) begin
      sh_src  <= reg_wdata[SRC_SHIFT +: SRC_W];
      sh_div  <= reg_wdata[DIV_SHIFT +: HID_W];
      sh_mode <= reg_wdata[MODE_SHIFT +: 2];
      sh_hw   <= reg_wdata[HW_BIT];
    end
  end

  assign cnt_hit[0] = reg_wr && (sel == SEL_M);
  assign cnt_hit[1] = reg_wr && (sel == SEL_N);
  assign cnt_hit[2] = reg_wr && (sel == SEL_D);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q[g] <= '0;
      else if (cnt_hit[g]) cnt_q[g] <= reg_wdata;
    end
  end

  assign sh_m = cnt_q[0][MND_W-1:0];
  assign sh_n = cnt_q[1][MND_W-1:0];
  assign sh_d = cnt_q[2][MND_W-1:0];

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CMD: begin
        reg_rdata[CMD_UPD_BIT] = pending;
        reg_rdata[CMD_OFF_BIT] = ~root_en;
      end
      SEL_CFG: begin
        reg_rdata[SRC_SHIFT +: SRC_W]  = sh_src;
        reg_rdata[DIV_SHIFT +: HID_W]  = sh_div;
        reg_rdata[MODE_SHIFT +: 2]     = sh_mode;
        reg_rdata[HW_BIT]              = sh_hw;
      end
      SEL_M:   reg_rdata = cnt_q[0];
      SEL_N:   reg_rdata = cnt_q[1];
      SEL_D:   reg_rdata = cnt_q[2];
      default: reg_rdata = '0;
    endcase
  end

  // R3: a counter word reads back what was last written to it
  p_cnt_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_M) |=> cnt_q[0] == $past(reg_wdata));
endmodule

// File: rtl/clkroot_active.sv
module clkroot_active #(
  parameter int HID_W = 5,
  parameter int SRC_W = 3,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRC_W-1:0] sh_src,
  input  logic [HID_W-1:0] sh_div,
  input  logic [1:0]       sh_mode,
  input  logic             sh_hw,
  input  logic [MND_W-1:0] sh_m,
  input  logic [MND_W-1:0] sh_n,
  input  logic [MND_W-1:0] sh_d,
  output logic [SRC_W-1:0] act_src,
  output logic [HID_W-1:0] act_div,
  output logic [1:0]       act_mode,
  output logic             act_hw,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_src  <= '0;
      act_div  <= '0;
      act_mode <= '0;
      act_hw   <= 1'b0;
      act_m    <= '0;
      act_n    <= '0;
      act_d    <= '0;
    end else if (load) begin
      act_src  <= sh_src;
      act_div  <= sh_div;
      act_mode <= sh_mode;
      act_hw   <= sh_hw;
      act_m    <= sh_m;
      act_n    <= sh_n;
      act_d    <= sh_d;
    end
  end

  // R5, R7: the load takes the shadow values present before the edge
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_m == $past(sh_m)) && (act_src == $past(sh_src)));
endmodule

// File: rtl/clkroot_ctrl.sv
module clkroot_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int GRP_OFS    = 32,
  parameter int HID_W      = 5,
  parameter int DIV_SHIFT  = 0,
  parameter int SRC_W      = 3,
  parameter int SRC_SHIFT  = 8,
  parameter int MODE_SHIFT = 12,
  parameter int HW_BIT     = 20,
  parameter int MND_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              root_en,
  output logic [SRC_W-1:0]  act_src_sel,
  output logic [HID_W-1:0]  act_pre_div,
  output logic [1:0]        act_mode,
  output logic              act_hw_ctrl,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  logic             set_req, pending, load;
  logic [SRC_W-1:0] sh_src;
  logic [HID_W-1:0] sh_div;
  logic [1:0]       sh_mode;
  logic             sh_hw;
  logic [MND_W-1:0] sh_m, sh_n, sh_d;

  clkroot_shadow #(
    .ADDR_W(ADDR_W), .GRP_OFS(GRP_OFS), .HID_W(HID_W), .DIV_SHIFT(DIV_SHIFT),
    .SRC_W(SRC_W), .SRC_SHIFT(SRC_SHIFT), .MODE_SHIFT(MODE_SHIFT),
    .HW_BIT(HW_BIT), .MND_W(MND_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .root_en(root_en),
    .pending(pending), .set_req(set_req), .sh_src(sh_src), .sh_div(sh_div),
    .sh_mode(sh_mode), .sh_hw(sh_hw), .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d)
  );

  clkroot_upd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .pending(pending), .load(load)
  );

  clkroot_active #(.HID_W(HID_W), .SRC_W(SRC_W), .MND_W(MND_W)) u_active (
    .clk(clk), .rst_n(rst_n), .load(load),
    .sh_src(sh_src), .sh_div(sh_div), .sh_mode(sh_mode), .sh_hw(sh_hw),
    .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
    .act_src(act_src_sel), .act_div(act_pre_div), .act_mode(act_mode),
    .act_hw(act_hw_ctrl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  // R6: active outputs move only on a load
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({act_src_sel, act_pre_div, act_mode, act_hw_ctrl,
                       act_m, act_n, act_d}));
  // R8: the off flag mirrors the enable input
  p_root_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[31] == !root_en));
endmodule

// File: tb/clkroot_ctrl_bench.sv
module clkroot_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int GRP    = 32;
  localparam logic [7:0] A_CMD = 8'd0;
  localparam logic [7:0] A_CFG = 8'(GRP + 4);
  localparam logic [7:0] A_M   = 8'(GRP + 8);
  localparam logic [7:0] A_N   = 8'(GRP + 12);
  localparam logic [7:0] A_D   = 8'(GRP + 16);

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:0] reg_addr;
  logic reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic root_en;
  logic [2:0] act_src_sel;
  logic [4:0] act_pre_div;
  logic [1:0] act_mode;
  logic act_hw_ctrl;
  logic [7:0] act_m, act_n, act_d;

  always #2 clk = ~clk;

  clkroot_ctrl u_clkroot_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .root_en(root_en),
    .act_src_sel(act_src_sel), .act_pre_div(act_pre_div), .act_mode(act_mode),
    .act_hw_ctrl(act_hw_ctrl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int due_q[$];
  logic [34:0] val_q[$];
  logic [34:0] prev_act = '0;

  // bench model of the shadow set
  logic [2:0] sm_src = '0; logic [4:0] sm_div = '0; logic [1:0] sm_mode = '0;
  logic sm_hw = 1'b0; logic [31:0] sm_m = '0, sm_n = '0, sm_d = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [34:0] model_pack();
    return {sm_src, sm_div, sm_mode, sm_hw, sm_m[7:0], sm_n[7:0], sm_d[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == A_CFG) begin
      sm_div = d[4:0]; sm_src = d[10:8]; sm_mode = d[13:12]; sm_hw = d[20];
    end
    if (a == A_M) sm_m = d;
    if (a == A_N) sm_n = d;
    if (a == A_D) sm_d = d;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic expect_load(input int due);
    due_q.push_back(due);
    val_q.push_back(model_pack());
  endtask

  // monitor: every change of the active set must match the queue head
  always @(negedge clk) begin
    logic [34:0] now;
    now = {act_src_sel, act_pre_div, act_mode, act_hw_ctrl, act_m, act_n, act_d};
    if (rst_n === 1'b1 && now !== prev_act) begin
      checks++;
      if (due_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected active change actual=%h expected=%h", now, prev_act);
      end else begin
        int due;
        logic [34:0] v;
        due = due_q.pop_front();
        v = val_q.pop_front();
        if (now !== v || cyc != due) begin
          errors++;
          $display("FAIL R5/R7 load actual=%h@%0d expected=%h@%0d", now, cyc, v, due);
        end
      end
    end
    prev_act = now;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0, c1;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; root_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CMD, d); chk("R1 cmd", d, 32'h0);
    rd(A_CFG, d); chk("R1 cfg", d, 32'h0);
    chk("R1 active", {29'd0, act_src_sel}, 32'h0);

    // R8 off flag
    root_en = 1'b0; rd(A_CMD, d); chk("R8 off", d, 32'h8000_0000);
    root_en = 1'b1; rd(A_CMD, d); chk("R8 on", d, 32'h0);

    // R2 field mapping, R6 no active change
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d); chk("R2 cfg mask", d, 32'h0010_371F);
    // R3 counters keep all bits
    wr(A_M, 32'hABCD_1234); rd(A_M, d); chk("R3 m", d, 32'hABCD_1234);
    wr(A_N, 32'h5555_00F0); rd(A_N, d); chk("R3 n", d, 32'h5555_00F0);
    wr(A_D, 32'h0000_0177); rd(A_D, d); chk("R3 d", d, 32'h0000_0177);
    idle(); idle();
    chk("R6 active held", {act_m, act_n, act_d, act_pre_div}, 32'h0);

    // R9 unmapped address
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R9 unmapped", d, 32'h0);
    rd(A_CFG, d); chk("R9 cfg intact", d, 32'h0010_371F);

    // R4 writing zero does nothing
    wr(A_CMD, 32'h0);
    rd(A_CMD, d); chk("R4 zero write", d, 32'h0);
    idle(); idle();

    // R4/R5 update sequence
    wr(A_CMD, 32'h1); c0 = cyc;
    expect_load(c0 + 2);
    rd(A_CMD, d); chk("R4 pending c0", d, 32'h1);
    idle();
    rd(A_CMD, d); chk("R4 pending c1", d, 32'h1);
    idle();
    rd(A_CMD, d); chk("R5 cleared c2", d, 32'h0);
    chk("R3 act m low bits", {24'd0, act_m}, 32'h34);

    // R7 write during pending is included
    wr(A_CMD, 32'h1); c0 = cyc;
    wr(A_M, 32'h0000_0099);
    expect_load(c0 + 2);
    chk("R7 active untouched while pending", {24'd0, act_m}, 32'h34);
    idle(); idle();
    chk("R7 m after load", {24'd0, act_m}, 32'h99);

    // R10 re-arm on the load edge
    wr(A_D, 32'h0000_0042);
    wr(A_CMD, 32'h1); c0 = cyc;
    idle();
    expect_load(c0 + 2);
    wr(A_CMD, 32'h1); c1 = cyc;
    rd(A_CMD, d); chk("R10 rearmed", d, 32'h1);
    wr(A_N, 32'h0000_0012);
    expect_load(c1 + 2);
    idle(); idle(); idle();
    rd(A_CMD, d); chk("R10 cleared", d, 32'h0);
    chk("R10 n after second load", {24'd0, act_n}, 32'h12);

    chk("R5 all loads seen", due_q.size(), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule